// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO bus. The host programs a control word with an enable bit and a clock divider. It then writes one command word that holds the operation, the PHY address, the register address, the write data and a start flag. While the start flag is set, the block shifts out a clause-22 management frame. On a read it samples the turnaround acknowledge and the sixteen data bits from the PHY. When the frame ends it clears the start flag, and the host polls that flag to learn that the access is over.

The host port is a plain single-cycle register interface with two locations: control (address 0) and command (address 1). Read data is registered and appears one clock after the address is presented. MDC toggles only while a frame is in flight and rests low otherwise. MDIO is driven with a separate output enable so that it can feed a tristate pad.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle set, enable clear, divider zero), the command word reads 0, and MDC and the MDIO output enable are low.
- R2: In the control word, bit 30 is the enable bit and bits DIV_W-1:0 are the divider; both read back as written. Bit 31 reads 1 when no frame is in flight and 0 while one is.
- R3: In the command word, bit 31 is the start flag, bit 30 selects write (1) or read (0), bits 25:21 are the register address, bits 20:16 are the PHY address and bits 15:0 are the data. The start flag reads 1 from the write that sets it until the frame ends, then reads 0 while the other fields keep their values.
- R4: While a frame is in flight, MDC has a period of 2*(divider+1) clock cycles with equal high and low halves. When no frame is in flight, MDC is low.
- R5: A write frame is exactly 64 MDC cycles. It carries 32 ones, start 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 data bits, each field MSB first. The output enable is high for the whole frame.
- R6: A read frame drives 32 ones, start 01, opcode 10, the PHY address and the register address. It then releases the output enable for the remaining 18 bit times (turnaround and data).
- R7: While the output is enabled, MDIO changes only on the clock edge where MDC falls.
- R8: On a read, bit 29 (acknowledge) is set at completion if the PHY drives MDIO low in the second turnaround bit, otherwise it is clear. Bits 15:0 then hold the 16 bits the PHY returned, MSB first.
- R9: A write to the command word while the start flag is set changes neither the stored fields nor the frame in flight.
- R10: While the enable bit is clear, a set start flag stays pending: MDC does not toggle and the idle bit stays 1. Setting the enable bit then runs the frame.
- R11: After a write frame, the acknowledge bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the host register port |
| host_addr | input | 1 | Register select: 0 control, 1 command |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data of the selected register |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high when the block drives the line |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench builds the block with its default parameters: an 8-bit divider and a 32-bit preamble, which gives the 64-bit frame. It programs divider values 0, 1 and 3, so MDC periods of 2, 4 and 8 clocks can be measured while whole frames stay a few hundred cycles long. A PHY model captures every bit and its output enable on the rising edge of MDC. The model answers reads with or without acknowledge, so both outcomes of the turnaround check are reached.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Command word bit positions (host-visible contract)
  localparam int GO_POS   = 31;
  localparam int WR_POS   = 30;
  localparam int ACK_POS  = 29;
  localparam int REG_LSB  = 21;
  localparam int PHY_LSB  = 16;
  // Control word bit positions
  localparam int IDLE_POS = 31;
  localparam int EN_POS   = 30;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
  } mdio_cmd_t;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_ACCESS = 1'b1
  } host_sel_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap     = run && (cnt >= div);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (run) begin
      if (cnt >= div) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4 / R10: the clock freezes whenever the frame is not allowed to advance
  a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  mdio_cmd_t cmd,
  input  logic      rise_stb,
  input  logic      fall_stb,
  input  logic      mdio_i,
  output logic      busy,
  output logic      done,
  output logic      mdio_o,
  output logic      mdio_oe,
  output logic      ack,
  output logic [15:0] rd_data
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 16);

  logic [FRAME_LEN-1:0] sreg;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx;
  logic                 wr_q;

  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             (cmd.wr ? 2'b01 : 2'b10),
             cmd.phy, cmd.rg,
             (cmd.wr ? 2'b10 : 2'b11),
             (cmd.wr ? cmd.data : 16'hFFFF)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      idx     <= '0;
      wr_q    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      ack     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        wr_q    <= cmd.wr;
        idx     <= '0;
        sreg    <= frame;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
        ack     <= 1'b0;
        rd_data <= '0;
      end else if (busy) begin
        if (rise_stb && !wr_q) begin
          if (idx == TA2_IDX) ack <= ~mdio_i;
          if (idx >= DAT_IDX) rd_data <= {rd_data[14:0], mdio_i};
        end
        if (fall_stb) begin
          if (idx == LAST_IDX) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            idx    <= idx + 1'b1;
            mdio_o <= sreg[FRAME_LEN-2];
            sreg   <= sreg << 1;
            if (!wr_q && (idx + 1'b1) == REL_IDX) mdio_oe <= 1'b0;
          end
        end
      end
    end
  end

  // R7: once a frame runs, the data line only moves with a falling MDC
  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && !$stable(mdio_o) |-> $past(fall_stb));
  // R5: a write frame keeps the line driven throughout
  a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
    busy && wr_q |-> mdio_oe);
  // R6: the line is released from the turnaround of a read onward
  a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
    busy && !wr_q && idx >= TA2_IDX |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic             go_q;
  logic             ack_q;
  mdio_cmd_t        cmd_q;

  logic        busy, done, start, run;
  logic        rise_stb, fall_stb, eng_ack;
  logic [15:0] eng_rd;
  logic        wr_access, wr_ctrl;
  logic [31:0] ctrl_word, access_word;
  logic        unused_bits;

  assign unused_bits = &host_wdata[29:26];
  assign wr_access = host_wr && (host_addr == SEL_ACCESS);
  assign wr_ctrl   = host_wr && (host_addr == SEL_CTRL);
  assign start     = go_q && en_q && !busy && !done;
  assign run       = busy && en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= '0;
      go_q  <= 1'b0;
      ack_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= host_wdata[EN_POS];
        div_q <= host_wdata[DIV_W-1:0];
      end
      if (done) begin
        go_q  <= 1'b0;
        ack_q <= eng_ack;
        if (!cmd_q.wr) cmd_q.data <= eng_rd;
      end else if (wr_access && !go_q) begin
        go_q       <= host_wdata[GO_POS];
        ack_q      <= 1'b0;
        cmd_q.wr   <= host_wdata[WR_POS];
        cmd_q.rg   <= host_wdata[REG_LSB +: 5];
        cmd_q.phy  <= host_wdata[PHY_LSB +: 5];
        cmd_q.data <= host_wdata[15:0];
      end
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[IDLE_POS]    = ~busy;
    ctrl_word[EN_POS]      = en_q;
    ctrl_word[DIV_W-1:0]   = div_q;
    access_word            = '0;
    access_word[GO_POS]    = go_q;
    access_word[WR_POS]    = cmd_q.wr;
    access_word[ACK_POS]   = ack_q;
    access_word[REG_LSB +: 5] = cmd_q.rg;
    access_word[PHY_LSB +: 5] = cmd_q.phy;
    access_word[15:0]      = cmd_q.data;
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= (host_addr == SEL_ACCESS) ? access_word : ctrl_word;
  end

  mdio_clk_div #(.DIV_W(DIV_W)) i_clk_div (
    .clk(clk), .rst(rst), .run(run), .div(div_q),
    .mdc(mdc_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) i_engine (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd_q),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .ack(eng_ack), .rd_data(eng_rd)
  );

  // R3: a frame in flight always has its start flag visible
  a_r3_go_during_frame: assert property (@(posedge clk) disable iff (rst)
    busy |-> go_q);
  // R9: a command write during an access leaves the stored command alone
  a_r9_locked_command: assert property (@(posedge clk) disable iff (rst)
    go_q && wr_access && !done |=> $stable(cmd_q));
  // R10: no frame starts while the block is disabled
  a_r10_wait_enable: assert property (@(posedge clk) disable iff (rst)
    go_q && !en_q && !busy |=> !busy);
endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  localparam int DIV_W = 8;
  localparam int PRE   = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_addr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // PHY model state
  int          rc = 0;
  logic [63:0] cap_frame = '0;
  logic [63:0] cap_oe = '0;
  time         last_rise = 0;
  time         per = 0;
  time         high_t = 0;
  bit          phy_ack = 1'b1;
  logic [15:0] phy_data = '0;
  int          viol = 0;
  logic        prev_o = 1'b0, prev_mdc = 1'b0, prev_oe = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.DIV_W(DIV_W), .PRE_LEN(PRE)) i_mdio_mgmt_master (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc_o) begin
    cap_frame = {cap_frame[62:0], mdio_o};
    cap_oe    = {cap_oe[62:0], mdio_oe};
    if (rc > 0) per = $time - last_rise;
    last_rise = $time;
    rc = rc + 1;
  end

  always @(negedge mdc_o) begin
    high_t = $time - last_rise;
    if (rc == PRE + 15)                       mdio_i = phy_ack ? 1'b0 : 1'b1;
    else if (rc >= PRE + 16 && rc <= PRE + 31) mdio_i = phy_data[PRE + 31 - rc];
    else                                      mdio_i = 1'b1;
  end

  // R7 monitor: while driven, the line may only move with a falling MDC
  always @(negedge clk) begin
    if (!rst && prev_oe && (mdio_o !== prev_o) && !(prev_mdc && !mdc_o)) viol = viol + 1;
    prev_o = mdio_o; prev_mdc = mdc_o; prev_oe = mdio_oe;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    for (int g = 0; g < 5000; g++) begin
      host_read(1'b1, v);
      if (!v[31]) return;
    end
    check(1'b0, {req, " timeout"}, 64'(v), 64'h0);
  endtask

  function automatic logic [31:0] cmd_word(bit go, bit wr, logic [4:0] rg, logic [4:0] phy, logic [15:0] d);
    return {go, wr, 4'b0, rg, phy, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    host_read(1'b0, v);
    check(v == 32'h8000_0000, "R1 ctrl", 64'(v), 64'h8000_0000);
    host_read(1'b1, v);
    check(v == 32'h0, "R1 access", 64'(v), 64'h0);
    check(mdc_o == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc_o, mdio_oe}, 64'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    host_write(1'b0, 32'h4000_0005);
    host_read(1'b0, v);
    check(v == 32'hC000_0005, "R2 ctrl readback", 64'(v), 64'hC000_0005);
  endtask

  task automatic t_write_frame();
    logic [31:0] v;
    logic [63:0] exp;
    host_write(1'b0, 32'h4000_0001);
    rc = 0;
    host_write(1'b1, cmd_word(1, 1, 5'h1A, 5'h05, 16'hBEEF));
    host_read(1'b1, v);
    check(v[31] == 1'b1, "R3 go held", 64'(v), 64'h1);
    host_read(1'b0, v);
    check(v[31] == 1'b0, "R2 idle clear while busy", 64'(v[31]), 64'h0);
    wait_done("R3");
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h1A, 2'b10, 16'hBEEF};
    check(cap_frame == exp, "R5 write frame", cap_frame, exp);
    check(cap_oe == '1, "R5 oe", cap_oe, '1);
    check(rc == 64, "R5 length", 64'(rc), 64);
    check(per == 16 && high_t == 8, "R4 period div1", 64'({per[31:0], high_t[31:0]}), {32'd16, 32'd8});
    host_read(1'b1, v);
    exp = 64'(cmd_word(0, 1, 5'h1A, 5'h05, 16'hBEEF));
    check(v == exp[31:0], "R3 fields after done", 64'(v), exp);
    check(v[29] == 1'b0, "R11 no ack on write", 64'(v[29]), 64'h0);
    check(mdc_o == 1'b0, "R4 mdc low idle", 64'(mdc_o), 64'h0);
  endtask

  task automatic t_read(input bit give_ack, input logic [15:0] d);
    logic [31:0] v;
    logic [45:0] hdr;
    host_write(1'b0, 32'h4000_0000);
    phy_ack = give_ack; phy_data = d; rc = 0;
    host_write(1'b1, cmd_word(1, 0, 5'h03, 5'h11, 16'h0));
    wait_done("R8");
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h11, 5'h03};
    check(cap_frame[63:18] == hdr, "R6 read header", 64'(cap_frame[63:18]), 64'(hdr));
    check(cap_oe == {{46{1'b1}}, 18'h0}, "R6 oe release", cap_oe, {{46{1'b1}}, 18'h0});
    check(per == 8, "R4 period div0", 64'(per), 64'd8);
    host_read(1'b1, v);
    check(v[31] == 1'b0 && v[29] == give_ack, "R8 ack", 64'(v[31:29]), 64'(give_ack));
    if (give_ack) check(v[15:0] == d, "R8 read data", 64'(v[15:0]), 64'(d));
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    logic [63:0] exp;
    host_write(1'b0, 32'h4000_0001);
    rc = 0;
    host_write(1'b1, cmd_word(1, 1, 5'h04, 5'h02, 16'h0F0F));
    host_write(1'b1, cmd_word(1, 0, 5'h1F, 5'h1F, 16'h0000));
    wait_done("R9");
    host_read(1'b1, v);
    exp = 64'(cmd_word(0, 1, 5'h04, 5'h02, 16'h0F0F));
    check(v == exp[31:0], "R9 fields kept", 64'(v), exp);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h02, 5'h04, 2'b10, 16'h0F0F};
    check(cap_frame == exp, "R9 frame kept", cap_frame, exp);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    host_write(1'b0, 32'h0000_0001);
    rc = 0;
    host_write(1'b1, cmd_word(1, 1, 5'h07, 5'h09, 16'hA5A5));
    repeat (100) @(negedge clk);
    check(rc == 0 && mdc_o == 1'b0, "R10 mdc held", 64'(rc), 64'h0);
    host_read(1'b1, v);
    check(v[31] == 1'b1, "R10 go pending", 64'(v[31]), 64'h1);
    host_read(1'b0, v);
    check(v[31] == 1'b1, "R10 idle while disabled", 64'(v[31]), 64'h1);
    host_write(1'b0, 32'h4000_0003);
    wait_done("R10");
    check(rc == 64, "R10 frame after enable", 64'(rc), 64);
    check(per == 32 && high_t == 16, "R4 period div3", 64'({per[31:0], high_t[31:0]}), {32'd32, 32'd16});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_write_frame();
    t_read(1'b1, 16'h1234);
    t_read(1'b0, 16'h5A5A);
    t_ignore();
    t_disabled();
    check(viol == 0, "R7 change only on fall", 64'(viol), 64'h0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule